// File: doc/BRIEF.md
# PCI Configuration Header with Command-Register Side Effects

This block is the target-side configuration register file of a PCI network adapter. It answers type-0 configuration reads and writes that an upstream bus unit has already decoded down to a dword address, a byte-enable mask and a data word. It holds the identification words: vendor, device, revision, header type and class code. It also holds the command word and an interface-control word. From the command word it drives the enables that gate I/O decode, memory decode and bus mastering elsewhere in the chip. A command word of zero therefore leaves only configuration accesses alive.

Vendor and device identifiers start from built-in defaults. An already-parsed word pair from an optional nonvolatile memory can replace them. Two command-register side effects set the block apart.

Dropping the bus-master bit while the automatic-reset enable is set launches an internal self-reset pulse of fixed length. The pulse clears the command word and any low-power request. It leaves the preloaded identifiers and the interface-control word alone.

A shutdown special-cycle message raises a sticky low-power request toward the attached LAN subsystem. This happens only when the special-cycle command bit is set. The request holds until a hardware reset or a self-reset clears it.

Top module: `cfg_header_unit`

## Requirements
- R1: After hardware reset, reads return 0508_104Ch at dword 0 (device in bits 31:16, vendor in bits 15:0), 0280_0001h at dword 2 (class code in bits 31:8, revision in bits 7:0) and 0000_0000h at dword 3 (header type 00h in bits 23:16).
- R2: A preload strobe replaces the vendor and device identifiers with the supplied words. A hardware reset restores the defaults.
- R3: After hardware reset the command word reads zero, and ioEnable, memEnable, masterEnable and lowPowerReq are low.
- R4: Command bit 0 drives ioEnable, bit 1 drives memEnable and bit 2 drives masterEnable. A write to dword 1 updates command bits 7:0 only when byte enable 0 is set, and bits 9:8 only when byte enable 1 is set.
- R5: Command bits 15:10 and the upper half of dword 1 always read zero.
- R6: Configuration writes to the identification dwords have no effect.
- R7: The interface-control word sits at dword 21 (byte offset 54h). Its bit 0 is the automatic-reset enable, written under byte enable 0 and cleared by hardware reset. All other bits read zero.
- R8: While automatic reset is enabled, a command write with byte enable 0 that takes bit 2 from 1 to 0 asserts selfReset for exactly RESET_CYCLES clocks, and the command word reads zero. No pulse occurs when automatic reset is disabled or bit 2 was already 0.
- R9: A self-reset leaves the interface-control word and the preloaded identifiers unchanged.
- R10: A special-cycle message of code 0000h sets lowPowerReq only while command bit 3 is set. Any other message code, or any message while bit 3 is clear, has no effect.
- R11: lowPowerReq stays high through later messages and command writes until a self-reset or hardware reset clears it.
- R12: Command writes that arrive while selfReset is high are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| cfgValid | input | 1 | Configuration access present this cycle |
| cfgWrite | input | 1 | 1 for write, 0 for read |
| cfgDwordAddr | input | ADDR_W | Configuration dword address |
| cfgByteEn | input | 4 | Byte enables, active high |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data for the addressed dword (combinational) |
| preloadValid | input | 1 | Parsed identifier words from nonvolatile memory are valid |
| preloadVendor | input | 16 | Vendor identifier to load |
| preloadDevice | input | 16 | Device identifier to load |
| specValid | input | 1 | Special-cycle message received |
| specMsg | input | 16 | Special-cycle message code |
| ioEnable | output | 1 | I/O space response enable |
| memEnable | output | 1 | Memory space response enable |
| masterEnable | output | 1 | Bus-master enable |
| lowPowerReq | output | 1 | Low-power request to the LAN subsystem |
| selfReset | output | 1 | Internal device reset pulse |

## Verification
The situation that is hardest to reach is a self-reset pulse that has another command write landing inside it. Three things must already be in place: the automatic-reset enable written, bus mastering on, and a low-power request already latched through a shutdown message with bit 3 set. The stimulus builds that state one write at a time. It then clears bit 2 and issues a second command write while the pulse is still running. Reads after the pulse show that the command word stayed zero and the request dropped, while the preloaded identifiers and the control word survived.

// File: rtl/cfg_header_pkg.sv
package cfg_header_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic cmdWrLo;   // update command bits 7:0
    logic cmdWrHi;   // update command bits 9:8
    logic cmdClear;  // force command to zero
    logic ctlWr;     // update interface-control
    logic idLoad;    // load preload identifiers
    logic lpSet;     // latch low-power request
    logic lpClear;   // drop low-power request
  } strobes_t;

  localparam int CMD_BITS = 10;
endpackage

// File: rtl/cfg_header_ctrl.sv
module cfg_header_ctrl
  import cfg_header_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int CMD_DWORD    = 1,
  parameter int CTL_DWORD    = 21,
  parameter int RESET_CYCLES = 4,
  parameter int MSG_W        = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  input  logic              cfgWrite,
  input  logic [ADDR_W-1:0] cfgDwordAddr,
  input  logic [3:0]        cfgByteEn,
  input  logic              wrMasterBit,
  input  logic              preloadValid,
  input  logic              specValid,
  input  logic [MSG_W-1:0]  specMsg,
  input  logic              masterBit,
  input  logic              specialBit,
  input  logic              autoRst,
  output strobes_t          strb,
  output logic              selfReset
);
  localparam int CNT_W = $clog2(RESET_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESET_CYCLES);

  logic [CNT_W-1:0] pulseCnt;
  logic busy, cmdWr, ctlHit, trigger, shutdownMsg;

  assign busy        = (pulseCnt != '0);
  assign cmdWr       = cfgValid && cfgWrite && (cfgDwordAddr == ADDR_W'(CMD_DWORD));
  assign ctlHit      = cfgValid && cfgWrite && (cfgDwordAddr == ADDR_W'(CTL_DWORD));
  assign trigger     = cmdWr && cfgByteEn[0] && masterBit && !wrMasterBit && autoRst && !busy;
  assign shutdownMsg = specValid && (specMsg == '0);

  always_comb begin
    strb          = '0;
    strb.cmdWrLo  = cmdWr && cfgByteEn[0] && !busy && !trigger;
    strb.cmdWrHi  = cmdWr && cfgByteEn[1] && !busy && !trigger;
    strb.cmdClear = trigger || busy;
    strb.ctlWr    = ctlHit && cfgByteEn[0];
    strb.idLoad   = preloadValid;
    strb.lpSet    = shutdownMsg && specialBit && !busy && !trigger;
    strb.lpClear  = trigger || busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        pulseCnt <= '0;
    else if (trigger) pulseCnt <= CNT_LOAD;
    else if (busy)    pulseCnt <= pulseCnt - 1'b1;
  end

  assign selfReset = busy;
endmodule

// File: rtl/cfg_header_dp.sv
module cfg_header_dp
  import cfg_header_pkg::*;
#(
  parameter int          ADDR_W      = 6,
  parameter int          CMD_DWORD   = 1,
  parameter int          CTL_DWORD   = 21,
  parameter logic [15:0] VENDOR_DEF  = 16'h104C,
  parameter logic [15:0] DEVICE_DEF  = 16'h0508,
  parameter logic [7:0]  REVISION    = 8'h01,
  parameter logic [7:0]  HEADER_TYPE = 8'h00,
  parameter logic [23:0] CLASS_CODE  = 24'h028000
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            strb,
  input  logic [CMD_BITS-1:0] wrBits,
  input  logic                wrCtlBit,
  input  logic [15:0]         preloadVendor,
  input  logic [15:0]         preloadDevice,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [31:0]         rdData,
  output logic [CMD_BITS-1:0] cmdReg,
  output logic                autoRst,
  output logic                lowPower
);
  logic [15:0] vendorId, deviceId;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vendorId <= VENDOR_DEF;
      deviceId <= DEVICE_DEF;
    end else if (strb.idLoad) begin
      vendorId <= preloadVendor;
      deviceId <= preloadDevice;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdReg <= '0;
    else if (strb.cmdClear) cmdReg <= '0;
    else begin
      if (strb.cmdWrLo) cmdReg[7:0] <= wrBits[7:0];
      if (strb.cmdWrHi) cmdReg[CMD_BITS-1:8] <= wrBits[CMD_BITS-1:8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           autoRst <= 1'b0;
    else if (strb.ctlWr) autoRst <= wrCtlBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             lowPower <= 1'b0;
    else if (strb.lpClear) lowPower <= 1'b0;
    else if (strb.lpSet)   lowPower <= 1'b1;
  end

  always_comb begin
    if (rdAddr == ADDR_W'(0))              rdData = {deviceId, vendorId};
    else if (rdAddr == ADDR_W'(CMD_DWORD)) rdData = {{(32-CMD_BITS){1'b0}}, cmdReg};
    else if (rdAddr == ADDR_W'(2))         rdData = {CLASS_CODE, REVISION};
    else if (rdAddr == ADDR_W'(3))         rdData = {8'h00, HEADER_TYPE, 16'h0000};
    else if (rdAddr == ADDR_W'(CTL_DWORD)) rdData = {31'd0, autoRst};
    else                                   rdData = '0;
  end
endmodule

// File: rtl/cfg_header_unit.sv
module cfg_header_unit
  import cfg_header_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int RESET_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  input  logic              cfgWrite,
  input  logic [ADDR_W-1:0] cfgDwordAddr,
  input  logic [3:0]        cfgByteEn,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  logic              preloadValid,
  input  logic [15:0]       preloadVendor,
  input  logic [15:0]       preloadDevice,
  input  logic              specValid,
  input  logic [15:0]       specMsg,
  output logic              ioEnable,
  output logic              memEnable,
  output logic              masterEnable,
  output logic              lowPowerReq,
  output logic              selfReset
);
  localparam int CMD_DWORD = 1;
  localparam int CTL_DWORD = 21;

  strobes_t            strb;
  logic [CMD_BITS-1:0] cmdReg;
  logic                autoRst;

  cfg_header_ctrl #(
    .ADDR_W(ADDR_W), .CMD_DWORD(CMD_DWORD), .CTL_DWORD(CTL_DWORD),
    .RESET_CYCLES(RESET_CYCLES), .MSG_W(16)
  ) i_ctrl (
    .clk, .rstN, .cfgValid, .cfgWrite, .cfgDwordAddr, .cfgByteEn,
    .wrMasterBit(cfgWrData[2]), .preloadValid, .specValid, .specMsg,
    .masterBit(cmdReg[2]), .specialBit(cmdReg[3]), .autoRst,
    .strb, .selfReset
  );

  cfg_header_dp #(
    .ADDR_W(ADDR_W), .CMD_DWORD(CMD_DWORD), .CTL_DWORD(CTL_DWORD)
  ) i_dp (
    .clk, .rstN, .strb, .wrBits(cfgWrData[CMD_BITS-1:0]), .wrCtlBit(cfgWrData[0]),
    .preloadVendor, .preloadDevice, .rdAddr(cfgDwordAddr), .rdData(cfgRdData),
    .cmdReg, .autoRst, .lowPower(lowPowerReq)
  );

  assign ioEnable     = cmdReg[0];
  assign memEnable    = cmdReg[1];
  assign masterEnable = cmdReg[2];
endmodule

// File: rtl/cfg_header_chk.sv
module cfg_header_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgValid,
  input logic              cfgWrite,
  input logic [ADDR_W-1:0] cfgDwordAddr,
  input logic [3:0]        cfgByteEn,
  input logic              wrMaster,
  input logic              specValid,
  input logic [15:0]       specMsg,
  input logic              ioEnable,
  input logic              memEnable,
  input logic              masterEnable,
  input logic              lowPowerReq,
  input logic              selfReset,
  input logic              autoRst
);
  p_reset_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!ioEnable && !memEnable && !masterEnable && !lowPowerReq && !selfReset));

  p_pulse_cmd_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    selfReset |-> (!ioEnable && !memEnable && !masterEnable));

  p_trigger_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && cfgWrite && cfgDwordAddr == ADDR_W'(1) && cfgByteEn[0] && masterEnable
     && !wrMaster && autoRst && !selfReset) |=> selfReset);

  p_pulse_lp_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    selfReset |-> !lowPowerReq);

  p_lp_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lowPowerReq) |-> $past(specValid && specMsg == 16'h0000));

  p_master_by_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(masterEnable) |-> $past(cfgValid && cfgWrite && cfgByteEn[0]));
endmodule

bind cfg_header_unit cfg_header_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk, .rstN, .cfgValid, .cfgWrite, .cfgDwordAddr, .cfgByteEn,
  .wrMaster(cfgWrData[2]), .specValid, .specMsg, .ioEnable, .memEnable,
  .masterEnable, .lowPowerReq, .selfReset, .autoRst(autoRst)
);

// File: tb/test_cfg_header_unit.sv
module test_cfg_header_unit;
  localparam int ADDR_W = 6;
  localparam int PULSE  = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgValid = 1'b0, cfgWrite = 1'b0;
  logic [ADDR_W-1:0] cfgDwordAddr = '0;
  logic [3:0] cfgByteEn = '0;
  logic [31:0] cfgWrData = '0, cfgRdData;
  logic preloadValid = 1'b0;
  logic [15:0] preloadVendor = '0, preloadDevice = '0;
  logic specValid = 1'b0;
  logic [15:0] specMsg = '0;
  logic ioEnable, memEnable, masterEnable, lowPowerReq, selfReset;

  int checks = 0, errors = 0, pulseLen = 0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  cfg_header_unit #(.ADDR_W(ADDR_W), .RESET_CYCLES(PULSE)) i_cfg_header_unit (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare reads against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && cfgValid && !cfgWrite && expQ.size() > 0)
      check(tagQ.pop_front(), cfgRdData, expQ.pop_front());
    if (selfReset) pulseLen++;
  end

  task automatic cfgWr(int addr, logic [3:0] be, logic [31:0] data);
    @(posedge clk) #1;
    cfgValid = 1; cfgWrite = 1; cfgDwordAddr = ADDR_W'(addr); cfgByteEn = be; cfgWrData = data;
    @(posedge clk) #1;
    cfgValid = 0; cfgWrite = 0;
  endtask

  task automatic cfgRd(int addr, logic [31:0] exp, string tag);
    @(posedge clk) #1;
    expQ.push_back(exp); tagQ.push_back(tag);
    cfgValid = 1; cfgWrite = 0; cfgDwordAddr = ADDR_W'(addr); cfgByteEn = 4'hF;
    @(posedge clk) #1;
    cfgValid = 0;
  endtask

  task automatic special(logic [15:0] code);
    @(posedge clk) #1;
    specValid = 1; specMsg = code;
    @(posedge clk) #1;
    specValid = 0;
  endtask

  task automatic enables(logic [3:0] exp, string tag);
    check(tag, {28'd0, lowPowerReq, masterEnable, memEnable, ioEnable}, {28'd0, exp});
  endtask

  task automatic hwReset();
    rstN = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    hwReset();
    enables(4'b0000, "R3 enables after reset");
    cfgRd(0, 32'h0508_104C, "R1 dword0 ids");
    cfgRd(2, 32'h0280_0001, "R1 class/revision");
    cfgRd(3, 32'h0000_0000, "R1 header type");
    cfgRd(1, 32'h0000_0000, "R3 command zero");

    cfgWr(0, 4'hF, 32'hFFFF_FFFF);
    cfgWr(2, 4'hF, 32'hFFFF_FFFF);
    cfgRd(0, 32'h0508_104C, "R6 ids read-only");
    cfgRd(2, 32'h0280_0001, "R6 class read-only");

    cfgWr(1, 4'b0001, 32'h0000_FFFF);
    cfgRd(1, 32'h0000_00FF, "R4 byte0 only");
    enables(4'b0111, "R4 enables on");
    cfgWr(1, 4'b0010, 32'hFFFF_FFFF);
    cfgRd(1, 32'h0000_03FF, "R5 reserved bits zero");
    cfgWr(1, 4'b0000, 32'h0);
    cfgRd(1, 32'h0000_03FF, "R4 no byte enable");
    pulseLen = 0;
    cfgWr(1, 4'b0001, 32'h0);
    cfgRd(1, 32'h0000_0300, "R4 byte0 cleared");
    check("R8 no pulse without auto-reset", pulseLen, 0);
    cfgWr(1, 4'b0011, 32'h0);

    @(posedge clk) #1;
    preloadValid = 1; preloadVendor = 16'h1234; preloadDevice = 16'hABCD;
    @(posedge clk) #1 preloadValid = 0;
    cfgRd(0, 32'hABCD_1234, "R2 preload ids");

    cfgWr(21, 4'b0001, 32'hFFFF_FFFF);
    cfgRd(21, 32'h0000_0001, "R7 auto-reset enable");

    special(16'h0000);
    check("R10 bit3 clear ignores shutdown", lowPowerReq, 0);
    cfgWr(1, 4'b0001, 32'h0000_000D);
    special(16'h0001);
    check("R10 other message ignored", lowPowerReq, 0);
    special(16'h0000);
    check("R10 shutdown sets request", lowPowerReq, 1);
    special(16'h0005);
    cfgWr(1, 4'b0001, 32'h0000_0005);
    check("R11 request held", lowPowerReq, 1);

    pulseLen = 0;
    cfgWr(1, 4'b0001, 32'h0000_0001);
    check("R8 pulse asserted", selfReset, 1);
    enables(4'b0000, "R8/R11 pulse clears command and request");
    cfgWr(1, 4'b0001, 32'h0000_0007);
    repeat (6) @(posedge clk);
    #1;
    check("R8 pulse length", pulseLen, PULSE);
    cfgRd(1, 32'h0, "R12 write during pulse dropped");
    cfgRd(21, 32'h0000_0001, "R9 control kept");
    cfgRd(0, 32'hABCD_1234, "R9 ids kept");

    pulseLen = 0;
    cfgWr(1, 4'b0001, 32'h0000_0001);
    cfgWr(1, 4'b0001, 32'h0000_0000);
    repeat (6) @(posedge clk);
    check("R8 no pulse when bit2 already clear", pulseLen, 0);

    cfgWr(1, 4'b0001, 32'h0000_000F);
    special(16'h0000);
    hwReset();
    enables(4'b0000, "R3 enables after second reset");
    cfgRd(0, 32'h0508_104C, "R2 defaults restored");
    cfgRd(21, 32'h0, "R7 control cleared by reset");

    @(posedge clk) #1;
    check("R1 scoreboard drained", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule